// File: doc/BRIEF.md
# Field-Based Control/Status Register

This block is one memory-mapped register whose bits are grouped into fields, each with its own access kind fixed at elaboration. A single register can hold writable storage, live status bits driven by hardware, event flags that software acknowledges by writing one, and command bits that exist only in the cycle of the write. Signal names follow the CPU's point of view: write data flows into the block and read data flows out.

The access kind of every bit comes from four mask parameters. A contiguous run of bits with the same kind forms one field. Storage bits take their reset value from a fifth parameter. A synchronous restore input returns the storage bits to those values without a system reset, for example after a link reset. Address decoding and bus adaptation sit outside the block. The block drives one bus write strobe with its write data and returns read data combinationally.

Top module: `csr_fld_reg`

## Requirements
- R1: Each bit takes its kind from the masks: a bit in STORE_MASK is storage, in STAT_MASK is status, in FLAG_MASK is a write-one-to-clear flag, in CMD_MASK is a write pulse, and in none of them is unused. The masks do not overlap. The default layout is storage [15:0], flags [19:16], pulses [23:20], status [27:24] and unused [31:28].
- R2: While bus_we_i is 1, storage bits load bus_wdata_i at the clock edge. hw_ctrl_o shows the stored bits and reads 0 on every other bit.
- R3: While rst_ni is 0, storage bits hold RST_VALUE and flags are 0. By default bits [15:0] reset to 9600 (16'h2580).
- R4: When soft_clr_i is 1, storage bits return to RST_VALUE at the next edge. This wins over a bus write in the same cycle. Flags are not affected.
- R5: Status bits read the current hw_status_i. Bus writes have no effect on them.
- R6: A 1 on hw_flag_set_i sets the flag at the next edge. A bus write of 1 to a flag bit clears it, and a write of 0 leaves it unchanged. A clear does not alter the other fields.
- R7: If a set and a write-one clear reach the same flag bit in the same cycle, the flag ends up set.
- R8: hw_pulse_o carries the pulse bits of bus_wdata_i only in a cycle where bus_we_i is 1. It is 0 in every other cycle. Pulse bits read as 0 on the bus.
- R9: bus_rdata_o shows the current field values in the same cycle, with no register stage. Unused bits read 0.
- R10: In the status-layout configuration (8 bits, all status), bit 0 is have, bit 1 is is_in, bits [5:2] are epno, bit 6 is pend and bit 7 is data. Every bit follows its hardware input.
- R11: hw_flag_set_i on non-flag bits and hw_status_i on non-status bits have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low system reset |
| soft_clr_i | input | 1 | Synchronous restore of the storage bits |
| bus_we_i | input | 1 | Bus write strobe |
| bus_wdata_i | input | REG_W | Bus write data |
| bus_rdata_o | output | REG_W | Bus read data |
| hw_status_i | input | REG_W | Hardware status values |
| hw_flag_set_i | input | REG_W | Hardware flag set requests |
| hw_ctrl_o | output | REG_W | Stored values to hardware |
| hw_pulse_o | output | REG_W | Single-cycle commands to hardware |

## Verification
Two events can reach the same state in one cycle: a hardware flag set can meet a software write-one clear on the same bit, and the restore input can meet a bus write to storage. The bench drives both pairs in a single cycle. In the flag case it also clears a neighbouring bit, so the same write shows one bit that survives and one that clears. The result is judged in the following cycle by reading the flag bits back over the bus and by checking hw_ctrl_o for the reset value rather than the written data.

// File: rtl/csr_fld_pkg.sv
package csr_fld_pkg;

    typedef enum logic [2:0] {
        FK_NONE  = 3'd0,
        FK_STORE = 3'd1,
        FK_STAT  = 3'd2,
        FK_FLAG  = 3'd3,
        FK_CMD   = 3'd4
    } fld_kind_e;

    function automatic fld_kind_e kind_of(input logic st, input logic ro,
                                          input logic fl, input logic cm);
        fld_kind_e k;
        k = FK_NONE;
        if (st)      k = FK_STORE;
        else if (ro) k = FK_STAT;
        else if (fl) k = FK_FLAG;
        else if (cm) k = FK_CMD;
        return k;
    endfunction

endpackage

// File: rtl/csr_fld_wrdec.sv
module csr_fld_wrdec #(
    parameter int unsigned REG_W = 32
) (
    input  logic             we_i,
    input  logic             clr_i,
    input  logic [REG_W-1:0] wdata_i,
    output logic             restore_o,
    output logic             load_o,
    output logic [REG_W-1:0] ack_o
);
    // restore outranks a bus load; a flag ack needs a strobe and a one
    assign restore_o = clr_i;
    assign load_o    = we_i & ~clr_i;
    assign ack_o     = wdata_i & {REG_W{we_i}};
endmodule

// File: rtl/csr_fld_cell.sv
module csr_fld_cell
    import csr_fld_pkg::*;
#(
    parameter fld_kind_e KIND    = FK_NONE,
    parameter logic      RST_BIT = 1'b0
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic restore_i,
    input  logic load_i,
    input  logic wbit_i,
    input  logic ack_i,
    input  logic set_i,
    input  logic status_i,
    output logic rd_o,
    output logic ctrl_o,
    output logic pulse_o
);
    generate
        if (KIND == FK_STORE) begin : g_store
            logic q;
            always_ff @(posedge clk_i or negedge rst_ni) begin
                if (!rst_ni)        q <= RST_BIT;
                else if (restore_i) q <= RST_BIT;
                else if (load_i)    q <= wbit_i;
            end
            assign rd_o    = q;
            assign ctrl_o  = q;
            assign pulse_o = 1'b0;
            logic unused_st;
            assign unused_st = ack_i ^ set_i ^ status_i;
        end else if (KIND == FK_FLAG) begin : g_flag
            logic q;
            always_ff @(posedge clk_i or negedge rst_ni) begin
                if (!rst_ni)    q <= 1'b0;
                else if (set_i) q <= 1'b1;
                else if (ack_i) q <= 1'b0;
            end
            assign rd_o    = q;
            assign ctrl_o  = 1'b0;
            assign pulse_o = 1'b0;
            logic unused_fl;
            assign unused_fl = restore_i ^ load_i ^ wbit_i ^ status_i;
        end else if (KIND == FK_STAT) begin : g_stat
            assign rd_o    = status_i;
            assign ctrl_o  = 1'b0;
            assign pulse_o = 1'b0;
            logic unused_ro;
            assign unused_ro = clk_i ^ rst_ni ^ restore_i ^ load_i ^ wbit_i ^ ack_i ^ set_i;
        end else if (KIND == FK_CMD) begin : g_cmd
            assign rd_o    = 1'b0;
            assign ctrl_o  = 1'b0;
            assign pulse_o = ack_i;
            logic unused_cm;
            assign unused_cm = clk_i ^ rst_ni ^ restore_i ^ load_i ^ wbit_i ^ set_i ^ status_i;
        end else begin : g_none
            assign rd_o    = 1'b0;
            assign ctrl_o  = 1'b0;
            assign pulse_o = 1'b0;
            logic unused_nn;
            assign unused_nn = clk_i ^ rst_ni ^ restore_i ^ load_i ^ wbit_i ^ ack_i ^ set_i ^ status_i;
        end
    endgenerate
endmodule

// File: rtl/csr_fld_reg.sv
module csr_fld_reg
    import csr_fld_pkg::*;
#(
    parameter int unsigned      REG_W      = 32,
    parameter logic [REG_W-1:0] STORE_MASK = 32'h0000_FFFF,
    parameter logic [REG_W-1:0] STAT_MASK  = 32'h0F00_0000,
    parameter logic [REG_W-1:0] FLAG_MASK  = 32'h000F_0000,
    parameter logic [REG_W-1:0] CMD_MASK   = 32'h00F0_0000,
    parameter logic [REG_W-1:0] RST_VALUE  = 32'h0000_2580
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             soft_clr_i,
    input  logic             bus_we_i,
    input  logic [REG_W-1:0] bus_wdata_i,
    output logic [REG_W-1:0] bus_rdata_o,
    input  logic [REG_W-1:0] hw_status_i,
    input  logic [REG_W-1:0] hw_flag_set_i,
    output logic [REG_W-1:0] hw_ctrl_o,
    output logic [REG_W-1:0] hw_pulse_o
);
    localparam logic [REG_W-1:0] USED_MASK = STORE_MASK | STAT_MASK | FLAG_MASK | CMD_MASK;

    logic             restore;
    logic             load;
    logic [REG_W-1:0] ack;
    logic [REG_W-1:0] rd_bits;
    logic [REG_W-1:0] ctrl_bits;
    logic [REG_W-1:0] pulse_bits;

    csr_fld_wrdec #(.REG_W(REG_W)) u_wrdec (
        .we_i      (bus_we_i),
        .clr_i     (soft_clr_i),
        .wdata_i   (bus_wdata_i),
        .restore_o (restore),
        .load_o    (load),
        .ack_o     (ack)
    );

    for (genvar i = 0; i < REG_W; i++) begin : g_bit
        csr_fld_cell #(
            .KIND    (kind_of(STORE_MASK[i], STAT_MASK[i], FLAG_MASK[i], CMD_MASK[i])),
            .RST_BIT (RST_VALUE[i] & STORE_MASK[i])
        ) u_cell (
            .clk_i     (clk_i),
            .rst_ni    (rst_ni),
            .restore_i (restore),
            .load_i    (load),
            .wbit_i    (bus_wdata_i[i]),
            .ack_i     (ack[i]),
            .set_i     (hw_flag_set_i[i]),
            .status_i  (hw_status_i[i]),
            .rd_o      (rd_bits[i]),
            .ctrl_o    (ctrl_bits[i]),
            .pulse_o   (pulse_bits[i])
        );
    end

    always_comb begin
        bus_rdata_o = rd_bits & USED_MASK;
        hw_ctrl_o   = ctrl_bits;
        hw_pulse_o  = pulse_bits;
    end
endmodule

// File: rtl/csr_fld_chk.sv
module csr_fld_chk #(
    parameter int unsigned      REG_W      = 32,
    parameter logic [REG_W-1:0] STORE_MASK = '0,
    parameter logic [REG_W-1:0] STAT_MASK  = '0,
    parameter logic [REG_W-1:0] FLAG_MASK  = '0,
    parameter logic [REG_W-1:0] CMD_MASK   = '0,
    parameter logic [REG_W-1:0] RST_VALUE  = '0
) (
    input logic             clk_i,
    input logic             rst_ni,
    input logic             soft_clr_i,
    input logic             bus_we_i,
    input logic [REG_W-1:0] bus_rdata_o,
    input logic [REG_W-1:0] hw_status_i,
    input logic [REG_W-1:0] hw_flag_set_i,
    input logic [REG_W-1:0] hw_ctrl_o,
    input logic [REG_W-1:0] hw_pulse_o
);
    localparam logic [REG_W-1:0] READ_MASK = STORE_MASK | STAT_MASK | FLAG_MASK;

    AST_RESTORE_VALUE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        soft_clr_i |=> (hw_ctrl_o == (RST_VALUE & STORE_MASK))); // R4

    AST_SET_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((hw_flag_set_i & FLAG_MASK) != '0) |=>
        ((bus_rdata_o & $past(hw_flag_set_i & FLAG_MASK)) == $past(hw_flag_set_i & FLAG_MASK))); // R7

    AST_PULSE_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !bus_we_i |-> (hw_pulse_o == '0)); // R8

    AST_UNREAD_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (bus_rdata_o & ~READ_MASK) == '0); // R9

    AST_STATUS_LIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (bus_rdata_o & STAT_MASK) == (hw_status_i & STAT_MASK)); // R5

    AST_CTRL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!bus_we_i && !soft_clr_i) |=> $stable(hw_ctrl_o)); // R2
endmodule

bind csr_fld_reg csr_fld_chk #(
    .REG_W      (REG_W),
    .STORE_MASK (STORE_MASK),
    .STAT_MASK  (STAT_MASK),
    .FLAG_MASK  (FLAG_MASK),
    .CMD_MASK   (CMD_MASK),
    .RST_VALUE  (RST_VALUE)
) u_chk (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .soft_clr_i    (soft_clr_i),
    .bus_we_i      (bus_we_i),
    .bus_rdata_o   (bus_rdata_o),
    .hw_status_i   (hw_status_i),
    .hw_flag_set_i (hw_flag_set_i),
    .hw_ctrl_o     (hw_ctrl_o),
    .hw_pulse_o    (hw_pulse_o)
);

// File: tb/csr_fld_reg_tb_top.sv
`timescale 1ns/100ps
module csr_fld_reg_tb_top;

    logic        clk = 1'b0;
    logic        rst_ni = 1'b0;
    logic        soft_clr = 1'b0;
    logic        we = 1'b0;
    logic [31:0] wdata = '0;
    logic [31:0] status = '0;
    logic [31:0] fset = '0;
    logic [31:0] rdata, ctrl, pulse;

    logic        lay_we = 1'b0;
    logic [7:0]  lay_wdata = '0;
    logic [7:0]  lay_status = '0;
    logic [7:0]  lay_rdata, lay_ctrl, lay_pulse;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    csr_fld_reg dut_i (
        .clk_i(clk), .rst_ni(rst_ni), .soft_clr_i(soft_clr),
        .bus_we_i(we), .bus_wdata_i(wdata), .bus_rdata_o(rdata),
        .hw_status_i(status), .hw_flag_set_i(fset),
        .hw_ctrl_o(ctrl), .hw_pulse_o(pulse)
    );

    // R10: status-only layout, have/is_in/epno/pend/data from bit 0 up
    csr_fld_reg #(
        .REG_W(8), .STORE_MASK(8'h00), .STAT_MASK(8'hFF),
        .FLAG_MASK(8'h00), .CMD_MASK(8'h00), .RST_VALUE(8'h00)
    ) lay_i (
        .clk_i(clk), .rst_ni(rst_ni), .soft_clr_i(1'b0),
        .bus_we_i(lay_we), .bus_wdata_i(lay_wdata), .bus_rdata_o(lay_rdata),
        .hw_status_i(lay_status), .hw_flag_set_i(8'h00),
        .hw_ctrl_o(lay_ctrl), .hw_pulse_o(lay_pulse)
    );

    typedef struct {
        int          kind;   // 0 rdata, 1 ctrl, 2 pulse, 3 layout rdata
        logic [31:0] mask;
        logic [31:0] val;
        string       req;
    } item_t;

    item_t sb[$];

    task automatic expect_q(input int kind, input logic [31:0] mask,
                            input logic [31:0] val, input string req);
        item_t it;
        it.kind = kind; it.mask = mask; it.val = val; it.req = req;
        sb.push_back(it);
    endtask

    task automatic cyc(input logic w, input logic [31:0] d, input logic c,
                       input logic [31:0] s, input logic [31:0] st);
        @(negedge clk);
        we = w; wdata = d; soft_clr = c; fset = s; status = st;
    endtask

    // monitor: compares queued expectations 1 ns after each falling edge
    always begin
        item_t it;
        logic [31:0] act;
        @(negedge clk);
        #1;
        while (sb.size() > 0) begin
            it = sb.pop_front();
            case (it.kind)
                0:       act = rdata;
                1:       act = ctrl;
                2:       act = pulse;
                default: act = {24'h0, lay_rdata};
            endcase
            checks++;
            if ((act & it.mask) !== it.val) begin
                fails++;
                $display("FAIL %s: actual %h expected %h (mask %h)",
                         it.req, act & it.mask, it.val, it.mask);
            end
        end
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_ni = 1'b1;

        // reset state, mixed layout (R1, R3)
        cyc(0, 0, 0, 0, 0);
        expect_q(0, 32'hFFFF_FFFF, 32'h0000_2580, "R3");
        expect_q(1, 32'hFFFF_FFFF, 32'h0000_2580, "R3");
        expect_q(2, 32'hFFFF_FFFF, 32'h0, "R1");

        // live status, unused and pulse bits read 0 (R5, R9, R8, R11)
        cyc(0, 0, 0, 0, 32'hFFFF_FFFF);
        expect_q(0, 32'h0F00_0000, 32'h0F00_0000, "R5");
        expect_q(0, 32'hF000_0000, 32'h0, "R9");
        expect_q(0, 32'h00F0_0000, 32'h0, "R8");
        expect_q(0, 32'h0000_FFFF, 32'h0000_2580, "R11");
        cyc(0, 0, 0, 0, 32'h0500_0000);
        expect_q(0, 32'h0F00_0000, 32'h0500_0000, "R9");

        // storage write; pulse during the strobe only
        cyc(1, 32'hFFFF_1234, 0, 0, 0);
        expect_q(2, 32'hFFFF_FFFF, 32'h00F0_0000, "R8");
        expect_q(0, 32'h0000_FFFF, 32'h0000_2580, "R2");
        cyc(0, 0, 0, 0, 0);
        expect_q(1, 32'hFFFF_FFFF, 32'h0000_1234, "R2");
        expect_q(0, 32'h0F00_0000, 32'h0, "R5");
        expect_q(0, 32'h000F_0000, 32'h0, "R6");
        expect_q(2, 32'hFFFF_FFFF, 32'h0, "R8");

        // hardware sets all flags; set on other bits ignored
        cyc(0, 0, 0, 32'hFFFF_FFFF, 0);
        cyc(0, 0, 0, 0, 0);
        expect_q(0, 32'h000F_0000, 32'h000F_0000, "R6");
        expect_q(1, 32'hFFFF_FFFF, 32'h0000_1234, "R11");

        // write-one clears, write-zero keeps
        cyc(1, 32'h0005_1234, 0, 0, 0);
        cyc(0, 0, 0, 0, 0);
        expect_q(0, 32'h000F_0000, 32'h000A_0000, "R6");
        expect_q(1, 32'hFFFF_FFFF, 32'h0000_1234, "R6");
        cyc(1, 32'h0000_1234, 0, 0, 0);
        cyc(0, 0, 0, 0, 0);
        expect_q(0, 32'h000F_0000, 32'h000A_0000, "R6");

        // set and clear on the same bit in one cycle
        cyc(1, 32'h000F_1234, 0, 32'h0002_0000, 0);
        cyc(0, 0, 0, 0, 0);
        expect_q(0, 32'h000F_0000, 32'h0002_0000, "R7");
        cyc(1, 32'h0002_1234, 0, 0, 0);
        cyc(0, 0, 0, 0, 0);
        expect_q(0, 32'h000F_0000, 32'h0, "R6");

        // restore beats a bus write; flags kept
        cyc(0, 0, 0, 32'h0001_0000, 0);
        cyc(1, 32'h0000_BEEF, 1, 0, 0);
        cyc(0, 0, 0, 0, 0);
        expect_q(1, 32'hFFFF_FFFF, 32'h0000_2580, "R4");
        expect_q(0, 32'h000F_0000, 32'h0001_0000, "R4");

        // restore alone after a write
        cyc(1, 32'h0000_00AA, 0, 0, 0);
        cyc(0, 0, 0, 0, 0);
        expect_q(1, 32'hFFFF_FFFF, 32'h0000_00AA, "R2");
        cyc(0, 0, 1, 0, 0);
        cyc(0, 0, 0, 0, 0);
        expect_q(0, 32'h0000_FFFF, 32'h0000_2580, "R4");

        // partial pulse pattern
        cyc(1, 32'h0050_00AA, 0, 0, 0);
        expect_q(2, 32'hFFFF_FFFF, 32'h0050_0000, "R8");
        expect_q(0, 32'h00F0_0000, 32'h0, "R8");
        cyc(0, 0, 0, 0, 0);
        expect_q(2, 32'hFFFF_FFFF, 32'h0, "R8");

        // status layout: have=1 is_in=0 epno=A pend=1 data=0 -> 69
        @(negedge clk);
        lay_status = {1'b0, 1'b1, 4'hA, 1'b0, 1'b1};
        expect_q(3, 32'hFF, 32'h69, "R10");
        @(negedge clk);
        lay_we = 1'b1; lay_wdata = 8'h00;
        expect_q(3, 32'hFF, 32'h69, "R10");
        @(negedge clk);
        lay_we = 1'b0;
        lay_status = {1'b1, 1'b0, 4'h5, 1'b1, 1'b0};
        expect_q(3, 32'hFF, 32'h96, "R10");

        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule